// File: doc/BRIEF.md
# Repeater Expansion Port Controller

This block sits on the expansion side of a multi-port Ethernet repeater. Several repeaters share one expansion bus through a central integrator. The controller asks for the bus with an active-low carrier output. It waits for the integrator's enable, which is synchronized inside the block, and then takes one of two roles. As the owner, it drives a 4-bit nibble bus with a data clock, a jam line and an error line. As a listener, it samples those same lines and hands the received nibbles to the local repeater core. The pads sit outside this block. Each bidirectional line comes through as an output value and an input value, and one registered output enable covers all of the driven lines.

Local transmit nibbles enter on a valid/ready stream. `tx_ready` is high only while the controller owns the bus and the strobe generator is ready for the next nibble. A nibble is taken on a clock edge where both `tx_valid` and `tx_ready` are high. While `tx_valid` is low, no data clock pulses are produced. Received nibbles leave on a valid-only stream. The bus cannot be stalled, so the sink must accept every `rx_valid` pulse.

Collision state is encoded on the jam and error lines together. Jam high with error high means one port is left. Jam high with error low means a collision between several repeaters. Jam low with error high means a plain transmit or receive error.

Top module: `xbus_port_ctrl`

## Requirements
- R1: Out of reset `bus_carrier_n` is high. It goes low on the first clock edge after `loc_carrier` is seen high in the idle state. It stays low in the request, transmit and collision states.
- R2: `bus_oe` is high only after the controller has asserted carrier and then seen the synchronized enable. While carrier is asserted without enable, `bus_oe` stays low, including in collision.
- R3: When the enable arrives while the local carrier is low, the controller receives. `bus_oe` stays low, and each rising edge of `bus_clk_i` yields exactly one `rx_valid` pulse carrying `bus_dat_i`, with nibbles kept in arrival order.
- R4: While transmitting, every accepted nibble appears on `bus_dat_o` with `bus_clk_o` low for one cycle and then high for one cycle. `bus_dat_o` holds steady across both cycles.
- R5: `tx_ready` is low outside the transmit state. When `tx_valid` is low, `bus_clk_o` stays low.
- R6: A low synchronized `bus_col_n` during request or transmit moves the controller into collision, which drives `bus_jam_o` high.
- R7: In collision, `bus_err_o` follows `loc_one_left`: 1 means one port left, 0 means a collision between several repeaters.
- R8: In transmit, `bus_jam_o` is 0 and `bus_err_o` follows `tx_err` with a one-cycle register delay.
- R9: While receiving, `rem_coll` reports the remote state: 2'b00 when jam is low, 2'b01 when jam is high and error is low, 2'b10 when both are high. `rx_err` is high when error is high and jam is low. Outside the receive state both read 0.
- R10: With the local carrier, the enable and the collision all released, the controller returns to idle. `bus_carrier_n` then goes high and `bus_oe` goes low.
- R11: Every integrator input passes through a two-stage synchronizer. A change on `bus_en` or `bus_col_n` reaches the outputs on the third clock edge after it and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_carrier | input | 1 | Local core has a packet for the bus |
| loc_one_left | input | 1 | Local collision has one port left |
| tx_valid | input | 1 | Transmit nibble valid |
| tx_ready | output | 1 | Transmit nibble accepted this edge |
| tx_data | input | 4 | Transmit nibble |
| tx_err | input | 1 | Local transmit error flag |
| rx_valid | output | 1 | Received nibble strobe |
| rx_data | output | 4 | Received nibble |
| rx_err | output | 1 | Receive error from the bus |
| rem_coll | output | 2 | Remote collision code |
| bus_carrier_n | output | 1 | Bus request, active low |
| bus_en | input | 1 | Integrator enable, active high |
| bus_col_n | input | 1 | Integrator collision, active low |
| bus_oe | output | 1 | Output enable for clock, jam, error and data pads |
| bus_clk_o | output | 1 | Data clock driven when owner |
| bus_clk_i | input | 1 | Data clock sampled when listener |
| bus_jam_o | output | 1 | Jam driven when owner |
| bus_jam_i | input | 1 | Jam sampled when listener |
| bus_err_o | output | 1 | Error driven when owner |
| bus_err_i | input | 1 | Error sampled when listener |
| bus_dat_o | output | 4 | Nibble driven when owner |
| bus_dat_i | input | 4 | Nibble sampled when listener |

## Verification
A wrong state register shows up at the pads within one edge of the transition that went astray. It appears as a carrier or output enable raised without the handshake, or as jam missing after a collision three edges later. A wrong phase in the strobe generator shows as a data clock high for two cycles or as data changing under a high clock, which is visible on the very next sample. A synchronizer that is too short or bypassed moves the enable and collision reactions one or two edges early, so the bench samples at both the second and the third edge after each input change.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_TX   = 3'd2,
    ST_RX   = 3'd3,
    ST_COL  = 3'd4
  } xst_e;

  localparam int unsigned NIB_W_DEF = 4;
  localparam int unsigned SYNC_DEF  = 2;
endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= RST_VAL;
        else        pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
  import xbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loc_carrier,
  input  logic loc_one_left,
  input  logic tx_err,
  input  logic en_s,
  input  logic col_s,
  output xst_e state_q,
  output logic bus_oe,
  output logic bus_err_o
);
  xst_e st_d;
  logic owns_d;

  always_comb begin
    st_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (loc_carrier)  st_d = ST_REQ;
        else if (en_s)    st_d = ST_RX;
      end
      ST_REQ: begin
        if (col_s)             st_d = ST_COL;
        else if (en_s)         st_d = ST_TX;
        else if (!loc_carrier) st_d = ST_IDLE;
      end
      ST_TX: begin
        if (col_s)                       st_d = ST_COL;
        else if (!loc_carrier && !en_s)  st_d = ST_IDLE;
      end
      ST_COL: begin
        if (!col_s && !loc_carrier && !en_s) st_d = ST_IDLE;
      end
      ST_RX: begin
        if (!en_s) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign owns_d = (st_d == ST_TX) || (st_d == ST_COL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bus_oe    <= 1'b0;
      bus_err_o <= 1'b0;
    end else begin
      state_q <= st_d;
      bus_oe  <= owns_d && en_s;
      if (st_d == ST_COL)     bus_err_o <= loc_one_left;
      else if (st_d == ST_TX) bus_err_o <= tx_err;
      else                    bus_err_o <= 1'b0;
    end
  end

  // R2: the enable may only rise out of a state that already requested the bus
  assert_oe_after_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> ($past(state_q) != ST_IDLE && $past(state_q) != ST_RX));

  assert_rx_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RX) |-> !bus_oe);

  assert_col_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_REQ || state_q == ST_TX) && col_s) |=> (state_q == ST_COL));

  assert_idle_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TX || state_q == ST_COL) && !loc_carrier && !en_s && !col_s)
      |=> (state_q == ST_IDLE));
endmodule

// File: rtl/xbus_tx.sv
module xbus_tx #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tx_valid,
  input  logic [NIB_W-1:0] tx_data,
  output logic             tx_ready,
  output logic             clk_o,
  output logic [NIB_W-1:0] dat_o
);
  logic phase_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi <= 1'b0;
      clk_o    <= 1'b0;
      dat_o    <= '0;
    end else if (!active) begin
      phase_hi <= 1'b0;
      clk_o    <= 1'b0;
    end else if (phase_hi) begin
      clk_o    <= 1'b1;
      phase_hi <= 1'b0;
    end else begin
      clk_o <= 1'b0;
      if (tx_valid) begin
        dat_o    <= tx_data;
        phase_hi <= 1'b1;
      end
    end
  end

  assign tx_ready = active && !phase_hi;

  assert_clk_single_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_o |=> !clk_o);

  assert_dat_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> $stable(dat_o));

  assert_no_strobe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |=> !clk_o);
endmodule

// File: rtl/xbus_rx.sv
module xbus_rx #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             clk_s,
  input  logic             jam_s,
  input  logic             err_s,
  input  logic [NIB_W-1:0] dat_s,
  output logic             rx_valid,
  output logic [NIB_W-1:0] rx_data,
  output logic             rx_err,
  output logic [1:0]       rem_coll
);
  logic clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= clk_s;
  end

  assign rx_valid = active && clk_s && !clk_prev;
  assign rx_data  = dat_s;
  assign rx_err   = active && err_s && !jam_s;
  assign rem_coll = (active && jam_s) ? (err_s ? 2'b10 : 2'b01) : 2'b00;

  assert_rx_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/xbus_port_ctrl.sv
module xbus_port_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned NIB_W  = NIB_W_DEF,
  parameter int unsigned STAGES = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_carrier,
  input  logic             loc_one_left,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [NIB_W-1:0] tx_data,
  input  logic             tx_err,
  output logic             rx_valid,
  output logic [NIB_W-1:0] rx_data,
  output logic             rx_err,
  output logic [1:0]       rem_coll,
  output logic             bus_carrier_n,
  input  logic             bus_en,
  input  logic             bus_col_n,
  output logic             bus_oe,
  output logic             bus_clk_o,
  input  logic             bus_clk_i,
  output logic             bus_jam_o,
  input  logic             bus_jam_i,
  output logic             bus_err_o,
  input  logic             bus_err_i,
  output logic [NIB_W-1:0] bus_dat_o,
  input  logic [NIB_W-1:0] bus_dat_i
);
  localparam int unsigned SW = NIB_W + 5;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 3'b000, {NIB_W{1'b0}}};

  logic [SW-1:0]    sync_q;
  logic             en_s, col_n_s, clk_s, jam_s, err_s;
  logic [NIB_W-1:0] dat_s;
  xst_e             state_q;

  xbus_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_en, bus_col_n, bus_clk_i, bus_jam_i, bus_err_i, bus_dat_i}),
    .q     (sync_q)
  );

  assign {en_s, col_n_s, clk_s, jam_s, err_s, dat_s} = sync_q;

  xbus_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .loc_carrier  (loc_carrier),
    .loc_one_left (loc_one_left),
    .tx_err       (tx_err),
    .en_s         (en_s),
    .col_s        (!col_n_s),
    .state_q      (state_q),
    .bus_oe       (bus_oe),
    .bus_err_o    (bus_err_o)
  );

  xbus_tx #(.NIB_W(NIB_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   ((state_q == ST_TX) && bus_oe),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .clk_o    (bus_clk_o),
    .dat_o    (bus_dat_o)
  );

  xbus_rx #(.NIB_W(NIB_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (state_q == ST_RX),
    .clk_s    (clk_s),
    .jam_s    (jam_s),
    .err_s    (err_s),
    .dat_s    (dat_s),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_err   (rx_err),
    .rem_coll (rem_coll)
  );

  assign bus_carrier_n = !((state_q == ST_REQ) || (state_q == ST_TX) || (state_q == ST_COL));
  assign bus_jam_o     = (state_q == ST_COL);

  assert_carrier_with_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_carrier_n);

  assert_tx_no_jam_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !bus_jam_o);
endmodule

// File: tb/xbus_port_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_port_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_carrier = 0, loc_one_left = 0, tx_valid = 0, tx_err = 0;
  logic [3:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_err, bus_carrier_n, bus_oe;
  logic [3:0] rx_data;
  logic [1:0] rem_coll;
  logic bus_en = 0, bus_col_n = 1, bus_clk_i = 0, bus_jam_i = 0, bus_err_i = 0;
  logic [3:0] bus_dat_i = '0;
  logic bus_clk_o, bus_jam_o, bus_err_o;
  logic [3:0] bus_dat_o;

  int checks = 0;
  int fails = 0;
  logic [3:0] cap [32];
  int cap_n = 0;
  bit capture_on = 0;
  int oe_in_rx = 0;

  always #4 clk = ~clk;

  xbus_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .loc_carrier(loc_carrier), .loc_one_left(loc_one_left),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_err(tx_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err), .rem_coll(rem_coll),
    .bus_carrier_n(bus_carrier_n), .bus_en(bus_en), .bus_col_n(bus_col_n),
    .bus_oe(bus_oe), .bus_clk_o(bus_clk_o), .bus_clk_i(bus_clk_i),
    .bus_jam_o(bus_jam_o), .bus_jam_i(bus_jam_i), .bus_err_o(bus_err_o),
    .bus_err_i(bus_err_i), .bus_dat_o(bus_dat_o), .bus_dat_i(bus_dat_i)
  );

  always @(negedge clk) begin
    if (capture_on) begin
      if (bus_oe) oe_in_rx++;
      if (rx_valid && cap_n < 32) begin
        cap[cap_n] = rx_data;
        cap_n++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset carrier_n", bus_carrier_n, 1);
    chk("R2 reset oe", bus_oe, 0);
    chk("R5 reset tx_ready", tx_ready, 0);
    chk("R3 reset rx_valid", rx_valid, 0);

    // Receive role: enable without local carrier
    bus_en = 1;
    tick(3);
    chk("R1 listener carrier_n", bus_carrier_n, 1);
    chk("R3 listener oe", bus_oe, 0);
    capture_on = 1;
    for (int i = 0; i < 16; i++) begin
      bus_dat_i = 4'(i); bus_clk_i = 0; tick(2);
      bus_clk_i = 1; tick(2);
    end
    bus_clk_i = 0;
    tick(4);
    capture_on = 0;
    chk("R3 rx count", cap_n, 16);
    for (int i = 0; i < 16; i++) chk("R3 rx nibble order", (i < cap_n) ? int'(cap[i]) : -1, i);
    chk("R3 oe during receive", oe_in_rx, 0);

    for (int c = 0; c < 4; c++) begin
      bus_jam_i = c[1]; bus_err_i = c[0];
      tick(3);
      chk("R9 rem_coll", rem_coll, c[1] ? (c[0] ? 2 : 1) : 0);
      chk("R9 rx_err", rx_err, (c[0] && !c[1]) ? 1 : 0);
    end
    bus_jam_i = 1; bus_err_i = 1;
    bus_en = 0;
    tick(3);
    chk("R9 rem_coll outside receive", rem_coll, 0);
    chk("R9 rx_err outside receive", rx_err, 0);
    bus_jam_i = 0; bus_err_i = 0;
    tick(2);

    // Transmit role
    loc_carrier = 1;
    tick(1);
    chk("R1 carrier after local packet", bus_carrier_n, 0);
    tick(4);
    chk("R2 no oe without enable", bus_oe, 0);
    chk("R5 no ready in request", tx_ready, 0);
    bus_en = 1;
    tick(2);
    chk("R11 enable not yet through", bus_oe, 0);
    tick(1);
    chk("R11 enable after third edge", bus_oe, 1);
    chk("R2 oe after grant", bus_oe, 1);
    chk("R5 ready in transmit", tx_ready, 1);
    for (int k = 0; k < 4; k++) begin
      tick(1);
      chk("R5 no strobe without valid", bus_clk_o, 0);
    end
    for (int i = 0; i < 16; i++) begin
      tx_valid = 1; tx_data = 4'(i); tx_err = i[0];
      tick(1);
      tx_valid = 0;
      chk("R4 data launched", bus_dat_o, i);
      chk("R4 clock low phase", bus_clk_o, 0);
      chk("R8 err follows tx_err", bus_err_o, i & 1);
      chk("R8 no jam in transmit", bus_jam_o, 0);
      tick(1);
      chk("R4 clock high phase", bus_clk_o, 1);
      chk("R4 data held", bus_dat_o, i);
    end
    tx_err = 0;

    // Collision while transmitting
    loc_one_left = 0;
    bus_col_n = 0;
    tick(2);
    chk("R11 collision not yet through", bus_jam_o, 0);
    tick(1);
    chk("R6 jam in collision", bus_jam_o, 1);
    chk("R7 multi collision err", bus_err_o, 0);
    chk("R2 oe kept in collision", bus_oe, 1);
    loc_one_left = 1;
    tick(1);
    chk("R7 one port left err", bus_err_o, 1);

    // Release everything
    bus_col_n = 1; loc_carrier = 0; bus_en = 0; loc_one_left = 0;
    tick(2);
    chk("R11 release not yet through", bus_carrier_n, 0);
    tick(1);
    chk("R10 carrier released", bus_carrier_n, 1);
    chk("R10 oe released", bus_oe, 0);
    chk("R10 jam released", bus_jam_o, 0);

    // Collision while only requesting
    loc_carrier = 1;
    tick(2);
    bus_col_n = 0;
    tick(3);
    chk("R6 jam from request", bus_jam_o, 1);
    chk("R2 no oe in ungranted collision", bus_oe, 0);
    chk("R1 carrier in collision", bus_carrier_n, 0);
    bus_col_n = 1; loc_carrier = 0;
    tick(4);
    chk("R10 idle after request collision", bus_carrier_n, 1);

    finish_run();
  end
endmodule